// File: doc/BRIEF.md
# Dual Interval Timer

This block holds two 16-bit down-counters behind a byte-wide register port. Both counters advance only on cycles where a tick-enable input is high. The tick is a fixed-rate strobe made elsewhere in the chip. Each counter drives an interrupt-flag output for an interrupt controller.

Timer 1 has a 16-bit reload latch and two modes, chosen by a single mode bit:
- **Free-running:** after the counter wraps from 0 to 0xFFFF it reloads from the latch on the next tick.
- **One-shot:** the counter keeps counting down through the wrap, and its flag fires only once per load.

Timer 2 is one-shot only and never reloads by itself.

Software loads a counter by writing the high byte of its counter address. Software clears a flag in one of three ways:
- writing a load address;
- writing the timer-1 latch high byte;
- reading a counter's low byte.

Reads return the live counter value combinationally. The clearing side effect happens only when `rd_en` is asserted.

Top module: `dual_interval_timer`

## Requirements
- R1: After synchronous reset both latches and both counters read 0xFFFF, the mode bit (address 0, bit 0) reads 0 (one-shot), and both flags are low.
- R2: A counter changes only on a cycle where `tick` is high, unless it is being loaded by a register write.
- R3: With the mode bit at 1, timer 1 raises its flag on the tick that takes its counter from 0 to 0xFFFF. The next tick reloads the counter from the latch, so one period is latch+2 ticks.
- R4: With the mode bit at 0, the timer-1 flag rises only on the first 0-to-0xFFFF wrap after a load. The counter keeps decrementing (0xFFFE and below) instead of reloading.
- R5: Writing address 1 or address 3 replaces only the low byte of the timer-1 latch. The counter value is not changed.
- R6: Writing address 2 stores the timer-1 latch high byte, loads the whole new latch value into the counter, re-arms one-shot firing and clears the timer-1 flag.
- R7: Writing address 4 stores the timer-1 latch high byte and clears the timer-1 flag, without touching the counter.
- R8: Address 1 reads the live timer-1 counter low byte and address 2 the high byte; addresses 3 and 4 read the latch low and high bytes. A read strobe on address 1 clears the timer-1 flag; a read strobe on address 2 leaves the flag unchanged.
- R9: Writing address 5 stores only the timer-2 latch low byte. Writing address 6 stores the high byte, loads the counter from the full latch, arms timer 2 and clears the timer-2 flag.
- R10: Timer 2 raises its flag on the first 0-to-0xFFFF wrap after a load and never reloads. Addresses 5 and 6 read its live counter bytes, and a read strobe on address 5 clears its flag.
- R11: If a flag would be set by a wrap and cleared by a read or latch-high write in the same cycle, it ends up set. A load write in the same cycle as a wrap leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (carries side effects only) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| t1_flag | output | 1 | Timer-1 interrupt flag |
| t2_flag | output | 1 | Timer-2 interrupt flag |

## Verification
The bench aims at the free-running period. A design that reloads on the zero tick instead of the tick after the wrap runs one tick short per period, so the flag drifts against the model. It also targets one-shot re-firing: a timer 1 or timer 2 that re-arms on its own, or reloads, fires a second time, and the model flags this. Byte-address side effects are exercised one at a time:
- a latch-high write that also reloads the counter shows up as a changed live count;
- a high-byte read that clears the flag shows up as a dropped flag.

Ticks are gated into irregular patterns so that any counting without a tick shows up, and a read-clear lands on a wrap cycle to pin down which action wins.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int CW = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       t1_flag,
  output logic       t2_flag
);
  localparam logic [2:0] A_MODE = 3'd0, A_T1CL = 3'd1, A_T1CH = 3'd2, A_T1LL = 3'd3,
                         A_T1LH = 3'd4, A_T2CL = 3'd5, A_T2CH = 3'd6;
  localparam logic [CW-1:0] ONES = '1;
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] l1, c1, l2, c2;
  logic cont, p1, a1, a2;

  wire ld1   = wr_en && addr == A_T1CH;
  wire ld2   = wr_en && addr == A_T2CH;
  wire wrap1 = tick && c1 == ZERO;
  wire wrap2 = tick && c2 == ZERO;
  wire fire1 = wrap1 && (cont || a1) && !ld1;
  wire fire2 = wrap2 && a2 && !ld2;
  wire clr1  = (wr_en && addr == A_T1LH) || (rd_en && addr == A_T1CL);
  wire clr2  = rd_en && addr == A_T2CL;

  always_ff @(posedge clk) begin
    if (rst) begin
      l1 <= ONES; c1 <= ONES; l2 <= ONES; c2 <= ONES;
      cont <= 1'b0; p1 <= 1'b0; a1 <= 1'b1; a2 <= 1'b0;
      t1_flag <= 1'b0; t2_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_MODE:          cont <= wdata[0];
          A_T1CL, A_T1LL:  l1[7:0] <= wdata;
          A_T1CH, A_T1LH:  l1[CW-1:8] <= wdata;
          A_T2CL:          l2[7:0] <= wdata;
          A_T2CH:          l2[CW-1:8] <= wdata;
          default: ;
        endcase
      end

      if (ld1) begin
        c1 <= {wdata, l1[7:0]};
        p1 <= 1'b0;
        a1 <= 1'b1;
      end else if (tick) begin
        c1 <= (p1 && cont) ? l1 : c1 - 1'b1;
        p1 <= c1 == ZERO;
        if (c1 == ZERO) a1 <= 1'b0;
      end

      if (ld2) begin
        c2 <= {wdata, l2[7:0]};
        a2 <= 1'b1;
      end else if (tick) begin
        c2 <= c2 - 1'b1;
        if (c2 == ZERO) a2 <= 1'b0;
      end

      if (ld1)        t1_flag <= 1'b0;
      else if (fire1) t1_flag <= 1'b1;
      else if (clr1)  t1_flag <= 1'b0;

      if (ld2)        t2_flag <= 1'b0;
      else if (fire2) t2_flag <= 1'b1;
      else if (clr2)  t2_flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rdata = {7'd0, cont};
      A_T1CL:  rdata = c1[7:0];
      A_T1CH:  rdata = c1[CW-1:8];
      A_T1LL:  rdata = l1[7:0];
      A_T1LH:  rdata = l1[CW-1:8];
      A_T2CL:  rdata = c2[7:0];
      A_T2CH:  rdata = c2[CW-1:8];
      default: rdata = 8'd0;
    endcase
  end

  AST_T1_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld1) |=> c1 == $past(c1)); // R2
  AST_T1_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && p1 && cont && !ld1) |=> c1 == $past(l1)); // R3
  AST_T1_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(t1_flag) |-> ($past(tick) && $past(c1) == ZERO)); // R3
  AST_T1_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (!cont && !a1 && !ld1) |=> !$rose(t1_flag)); // R4
  AST_T1_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld1 |=> (c1 == {$past(wdata), $past(l1[7:0])} && !t1_flag)); // R6
  AST_T2_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && c2 == ZERO && !ld2) |=> c2 == ONES); // R10
  AST_T2_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld2 |=> (c2 == {$past(wdata), $past(l2[7:0])} && !t2_flag)); // R9
endmodule

// File: tb/dual_interval_timer_bench.sv
`timescale 1ns/1ps
module dual_interval_timer_bench;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic t1_flag, t2_flag;
  int checks = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .t1_flag(t1_flag), .t2_flag(t2_flag));

  int m_l1, m_c1, m_l2, m_c2, o1, o2, ol1, ol2;
  bit m_cont, m_p1, m_a1, m_a2, m_f1, m_f2, oc, ld1, ld2, fr1, fr2, cl1, cl2;

  always @(posedge clk) begin
    if (rst) begin
      m_l1 = 'hFFFF; m_c1 = 'hFFFF; m_l2 = 'hFFFF; m_c2 = 'hFFFF;
      m_cont = 0; m_p1 = 0; m_a1 = 1; m_a2 = 0; m_f1 = 0; m_f2 = 0;
    end else begin
      o1 = m_c1; o2 = m_c2; ol1 = m_l1; ol2 = m_l2; oc = m_cont;
      ld1 = wr_en && addr == 2; ld2 = wr_en && addr == 6;
      fr1 = tick && o1 == 0 && (oc || m_a1) && !ld1;
      fr2 = tick && o2 == 0 && m_a2 && !ld2;
      cl1 = (wr_en && addr == 4) || (rd_en && addr == 1);
      cl2 = rd_en && addr == 5;
      if (wr_en) begin
        if (addr == 0) m_cont = wdata[0];
        if (addr == 1 || addr == 3) m_l1 = (ol1 & 'hFF00) | wdata;
        if (addr == 2 || addr == 4) m_l1 = (ol1 & 'hFF) | (int'(wdata) << 8);
        if (addr == 5) m_l2 = (ol2 & 'hFF00) | wdata;
        if (addr == 6) m_l2 = (ol2 & 'hFF) | (int'(wdata) << 8);
      end
      if (ld1) begin m_c1 = m_l1; m_p1 = 0; m_a1 = 1; end
      else if (tick) begin
        m_c1 = (m_p1 && oc) ? ol1 : (o1 - 1) & 'hFFFF;
        m_p1 = (o1 == 0);
        if (o1 == 0) m_a1 = 0;
      end
      if (ld2) begin m_c2 = m_l2; m_a2 = 1; end
      else if (tick) begin
        m_c2 = (o2 - 1) & 'hFFFF;
        if (o2 == 0) m_a2 = 0;
      end
      m_f1 = ld1 ? 0 : fr1 ? 1 : cl1 ? 0 : m_f1;
      m_f2 = ld2 ? 0 : fr2 ? 1 : cl2 ? 0 : m_f2;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return int'(m_cont);
      1: return m_c1 & 'hFF;
      2: return m_c1 >> 8;
      3: return m_l1 & 'hFF;
      4: return m_l1 >> 8;
      5: return m_c2 & 'hFF;
      6: return m_c2 >> 8;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(rdata) != exp_rd(int'(addr)) || t1_flag !== m_f1 || t2_flag !== m_f2) begin
        fails++;
        $display("FAIL %s addr=%0d actual rdata=%h f1=%b f2=%b expected rdata=%h f1=%b f2=%b",
                 phase, addr, rdata, t1_flag, t2_flag, exp_rd(int'(addr)), m_f1, m_f2);
      end
    end
  end

  task automatic step(input bit w, input bit r, input int a, input int d, input bit t);
    @(negedge clk); #1;
    wr_en = w; rd_en = r; addr = 3'(a); wdata = 8'(d); tick = t;
  endtask

  task automatic expect_rd(input int a, input int e, input string tag);
    step(0, 0, a, 0, 0);
    @(negedge clk); #0.5;
    checks++;
    if (int'(rdata) != e) begin
      fails++;
      $display("FAIL %s addr=%0d actual %h expected %h", tag, a, rdata, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    phase = "R1";
    for (int a = 1; a <= 6; a++) expect_rd(a, 'hFF, "R1");
    expect_rd(0, 0, "R1");
    checks++;
    if (t1_flag !== 0 || t2_flag !== 0) begin
      fails++; $display("FAIL R1 flags actual %b%b expected 00", t1_flag, t2_flag);
    end

    phase = "R2";
    for (int i = 0; i < 12; i++) step(0, 0, 1, 0, (i % 3) == 0);

    phase = "R5";
    step(1, 0, 1, 'h05, 0);
    step(1, 0, 3, 'h06, 0);
    step(0, 0, 1, 0, 0);
    expect_rd(3, 'h06, "R5");

    phase = "R7";
    step(1, 0, 4, 'h00, 0);
    step(0, 0, 2, 0, 1);
    expect_rd(4, 'h00, "R7");

    phase = "R6";
    step(1, 0, 2, 'h00, 0);
    expect_rd(1, 'h06, "R6");

    phase = "R4";
    for (int i = 0; i < 24; i++) step(0, 0, 1, 0, 1);
    phase = "R8";
    step(0, 1, 2, 0, 0);
    step(0, 0, 2, 0, 0);
    step(0, 1, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    phase = "R4";
    for (int i = 0; i < 20; i++) step(0, 0, 2, 0, 1);

    phase = "R3";
    step(1, 0, 0, 1, 0);
    step(1, 0, 2, 0, 0);
    for (int i = 0; i < 60; i++) step(0, (i % 11) == 10, 1, 0, (i % 4) != 3);
    step(1, 0, 3, 'h02, 1);
    for (int i = 0; i < 30; i++) step(0, (i % 7) == 6, 1, 0, 1);

    phase = "R11";
    step(1, 0, 3, 'h00, 0);
    step(1, 0, 2, 'h00, 0);
    for (int i = 0; i < 16; i++) step(0, 1, 1, 0, 1);
    for (int i = 0; i < 12; i++) step(i == 5, 0, 2, 0, 1);
    for (int i = 0; i < 10; i++) step(i % 2, 0, 4, 0, 1);

    phase = "R9";
    step(1, 0, 5, 'h03, 0);
    step(0, 0, 5, 0, 0);
    step(1, 0, 6, 'h00, 0);
    expect_rd(5, 'h03, "R9");

    phase = "R10";
    for (int i = 0; i < 12; i++) step(0, 0, 6, 0, 1);
    step(0, 1, 6, 0, 0);
    step(0, 0, 6, 0, 0);
    step(0, 1, 5, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 5, 0, 1);
    step(1, 0, 6, 'h00, 0);
    for (int i = 0; i < 8; i++) step(0, (i == 4), 5, 0, 1);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    done = 1;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule